// File: doc/BRIEF.md
# Priority-Queued Memory Request Scheduler

This block sits in front of a memory and decides which pending access goes next. Requesters present reads and writes one per cycle, each with an address, a byte count, a requester tag and a priority level. The block keeps a separate set of queues for reads and for writes. Each set has one FIFO per priority level. Buffer space is counted in memory-packet units rather than in requests, so a large access uses more of its direction's budget than a small one.

An external direction select chooses whether reads or writes are served. Once the issue pacing timer allows it, the block pops the oldest request from the highest non-empty priority of that direction and presents it on the issue port for one cycle. The same request reappears on the response port a fixed number of cycles later. A request that does not fit is refused. The block then counts the refusal and remembers that a requester of that direction is waiting. The next issue in that direction carries a one-cycle retry pulse that tells the requester to try again. A drain indication stays high while either direction still holds buffered units.

A cycle in which `req_valid` is high counts as one attempt. If `req_ready` is low in that cycle, the attempt is a rejection. The requester is expected to drop the request and wait for `retry`.

Top module: `qos_req_sched`

## Requirements
- R1: A request of S bytes needs ceil(S / PKT_BYTES) units. A size of 0 needs one unit.
- R2: `req_ready` is high when the buffered read units plus the units of the presented read do not exceed RD_CAP. A read presented while `req_ready` is low is not stored, and `rd_rejects` rises by one.
- R3: Writes follow the same rule against WR_CAP, with their own counter `wr_rejects`. Write refusals leave the read budget and `rd_rejects` unchanged.
- R4: Only the direction chosen by `dir_write` (1 = writes, 0 = reads) is served. Within it, the highest priority value with a queued request wins. Within one priority, requests leave in arrival order.
- R5: `iss_valid` is a one-cycle pulse. Two issues are at least REQ_LAT cycles apart. While pacing allows it and the selected direction is non-empty, an issue follows at the next clock edge.
- R6: Every issued request appears on the response port exactly RSP_LAT cycles after its `iss_valid`, with the same tag, address and direction.
- R7: `retry` pulses only together with an issue, and only when a rejection in the issued direction has happened since that direction last pulsed. At most one pulse is sent per issue. A pending rejection in the other direction gives no pulse.
- R8: `draining` is high while the read or the write unit count is non-zero, and low only when both are zero. No issue can follow a cycle in which `draining` is low.
- R9: When an accepted request and an issue in the same direction share a clock edge, the unit count becomes old + added − freed. The admission check in that cycle uses the old count.
- R10: After reset, there are no issue, response or retry pulses, `draining` is low, both counters are zero, and an empty block accepts any request that fits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request attempt this cycle |
| req_ready | output | 1 | Presented request fits its direction's budget |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_size | input | SIZE_W | Request byte count |
| req_id | input | ID_W | Requester tag |
| req_prio | input | PRIO_W | Priority, higher value served first, below NPRIO |
| dir_write | input | 1 | Direction to serve: 1 = writes, 0 = reads |
| iss_valid | output | 1 | One-cycle issue pulse to memory |
| iss_write | output | 1 | Direction of the issued request |
| iss_addr | output | ADDR_W | Issued address |
| iss_size | output | SIZE_W | Issued byte count |
| iss_id | output | ID_W | Issued tag |
| rsp_valid | output | 1 | Response pulse |
| rsp_write | output | 1 | Direction of the response |
| rsp_addr | output | ADDR_W | Response address |
| rsp_id | output | ID_W | Response tag |
| retry | output | 1 | Retry pulse for the direction just issued |
| draining | output | 1 | Buffered units remain |
| rd_rejects | output | CNT_W | Refused read attempts |
| wr_rejects | output | CNT_W | Refused write attempts |

## Verification
The hardest state to reach from the ports is a full read budget whose contents sit unserved across several priorities. Issues fire as soon as anything is queued. The bench therefore holds `dir_write` on the empty write side while a vector table fills the read side, including over-budget attempts. It then flips the direction in the same cycle that it presents a write. This checks the strict-priority order and the single direction-matched retry. The simultaneous accept-and-free case is reached by queueing one read with writes selected. The bench then switches to reads in the very cycle a second read arrives, and probes `req_ready` afterwards without a valid request to read back the resulting unit count.

// File: rtl/qos_req_sched.sv
`timescale 1ns/1ps
module qos_req_sched #(
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 8,
  parameter int ID_W      = 4,
  parameter int NPRIO     = 4,
  parameter int PKT_BYTES = 16,
  parameter int RD_CAP    = 6,
  parameter int WR_CAP    = 4,
  parameter int REQ_LAT   = 4,
  parameter int RSP_LAT   = 3,
  parameter int CNT_W     = 16,
  localparam int PRIO_W   = (NPRIO > 1) ? $clog2(NPRIO) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ID_W-1:0]   req_id,
  input  logic [PRIO_W-1:0] req_prio,
  input  logic              dir_write,
  output logic              iss_valid,
  output logic              iss_write,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [SIZE_W-1:0] iss_size,
  output logic [ID_W-1:0]   iss_id,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ID_W-1:0]   rsp_id,
  output logic              retry,
  output logic              draining,
  output logic [CNT_W-1:0]  rd_rejects,
  output logic [CNT_W-1:0]  wr_rejects
);
  localparam int QD    = (RD_CAP > WR_CAP) ? RD_CAP : WR_CAP;
  localparam int PTR_W = (QD > 1) ? $clog2(QD) : 1;
  localparam int CW    = $clog2(QD + 1);
  localparam int SW    = ((CW > SIZE_W + 1) ? CW : SIZE_W + 1) + 1;
  localparam int GAP_W = $clog2(REQ_LAT + 1) + 1;
  localparam logic [SIZE_W:0] PKT = (SIZE_W+1)'(PKT_BYTES);

  function automatic logic [SIZE_W:0] units(input logic [SIZE_W-1:0] sz);
    return (sz == '0) ? (SIZE_W+1)'(1) : ({1'b0, sz} + PKT - 1'b1) / PKT;
  endfunction

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QD - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [ADDR_W-1:0] q_addr [2][NPRIO][QD];
  logic [SIZE_W-1:0] q_size [2][NPRIO][QD];
  logic [ID_W-1:0]   q_id   [2][NPRIO][QD];
  logic [PTR_W-1:0]  wp [2][NPRIO];
  logic [PTR_W-1:0]  rp [2][NPRIO];
  logic [CW-1:0]     qc [2][NPRIO];
  logic [CW-1:0]     occ [2];
  logic [1:0]        rflag;
  logic [GAP_W-1:0]  pace;

  logic              sel_hit, fire, acc, rej;
  logic [PRIO_W-1:0] sel_p;
  logic [SIZE_W:0]   need, hunits;
  logic [SIZE_W-1:0] h_size;
  logic              dsel;

  assign dsel = dir_write;
  assign need = units(req_size);
  assign req_ready = req_write ? (SW'(occ[1]) + SW'(need) <= SW'(WR_CAP))
                               : (SW'(occ[0]) + SW'(need) <= SW'(RD_CAP));
  assign acc = req_valid && req_ready;
  assign rej = req_valid && !req_ready;
  assign draining = (occ[0] != '0) || (occ[1] != '0);

  always_comb begin
    sel_hit = 1'b0;
    sel_p = '0;
    for (int p = 0; p < NPRIO; p++)
      if (qc[dsel][p] != '0) begin
        sel_hit = 1'b1;
        sel_p = PRIO_W'(p);
      end
  end

  assign fire   = sel_hit && (pace == '0);
  assign h_size = q_size[dsel][sel_p][rp[dsel][sel_p]];
  assign hunits = units(h_size);

  always_ff @(posedge clk)
    if (acc) begin
      q_addr[req_write][req_prio][wp[req_write][req_prio]] <= req_addr;
      q_size[req_write][req_prio][wp[req_write][req_prio]] <= req_size;
      q_id[req_write][req_prio][wp[req_write][req_prio]]   <= req_id;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        occ[d] <= '0;
        for (int p = 0; p < NPRIO; p++) begin
          wp[d][p] <= '0;
          rp[d][p] <= '0;
          qc[d][p] <= '0;
        end
      end
      rflag <= '0;
      pace <= '0;
      rd_rejects <= '0;
      wr_rejects <= '0;
      iss_valid <= 1'b0;
      iss_write <= 1'b0;
      iss_addr <= '0;
      iss_size <= '0;
      iss_id <= '0;
      retry <= 1'b0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        for (int p = 0; p < NPRIO; p++) begin
          if (acc && int'(req_write) == d && int'(req_prio) == p)
            wp[d][p] <= bump(wp[d][p]);
          if (fire && int'(dsel) == d && int'(sel_p) == p)
            rp[d][p] <= bump(rp[d][p]);
          qc[d][p] <= qc[d][p]
                    + CW'(acc && int'(req_write) == d && int'(req_prio) == p)
                    - CW'(fire && int'(dsel) == d && int'(sel_p) == p);
        end
        occ[d] <= CW'(SW'(occ[d])
                  + ((acc && int'(req_write) == d) ? SW'(need) : SW'(0))
                  - ((fire && int'(dsel) == d) ? SW'(hunits) : SW'(0)));
        rflag[d] <= (rflag[d] && !(fire && int'(dsel) == d))
                  || (rej && int'(req_write) == d);
      end
      if (fire) pace <= GAP_W'(REQ_LAT - 1);
      else if (pace != '0) pace <= pace - 1'b1;
      if (rej && !req_write) rd_rejects <= rd_rejects + 1'b1;
      if (rej && req_write)  wr_rejects <= wr_rejects + 1'b1;
      iss_valid <= fire;
      retry <= fire && rflag[dsel];
      if (fire) begin
        iss_write <= dsel;
        iss_addr <= q_addr[dsel][sel_p][rp[dsel][sel_p]];
        iss_size <= h_size;
        iss_id <= q_id[dsel][sel_p][rp[dsel][sel_p]];
      end
    end
  end

  logic              pv [RSP_LAT];
  logic              pw [RSP_LAT];
  logic [ADDR_W-1:0] pa [RSP_LAT];
  logic [ID_W-1:0]   pi [RSP_LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < RSP_LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= iss_valid;
      for (int k = 1; k < RSP_LAT; k++) pv[k] <= pv[k-1];
    end
    pw[0] <= iss_write;
    pa[0] <= iss_addr;
    pi[0] <= iss_id;
    for (int k = 1; k < RSP_LAT; k++) begin
      pw[k] <= pw[k-1];
      pa[k] <= pa[k-1];
      pi[k] <= pi[k-1];
    end
  end

  assign rsp_valid = pv[RSP_LAT-1];
  assign rsp_write = pw[RSP_LAT-1];
  assign rsp_addr  = pa[RSP_LAT-1];
  assign rsp_id    = pi[RSP_LAT-1];

  logic [GAP_W-1:0] gap;
  always_ff @(posedge clk)
    if (!rst_n) gap <= GAP_W'(REQ_LAT);
    else if (iss_valid) gap <= GAP_W'(1);
    else if (gap < GAP_W'(REQ_LAT)) gap <= gap + 1'b1;

  // R2
  rd_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SW'(occ[0]) <= SW'(RD_CAP));
  // R3
  wr_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SW'(occ[1]) <= SW'(WR_CAP));
  // R2
  rd_reject_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !req_write) |=> rd_rejects == $past(rd_rejects) + 1'b1);
  // R5
  issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> gap >= GAP_W'(REQ_LAT));
  // R7
  retry_with_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> iss_valid);
  // R8
  idle_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !draining |=> !iss_valid);
endmodule

// File: tb/qos_req_sched_tb_top.sv
`timescale 1ns/1ps
module qos_req_sched_tb_top;
  localparam real CLK = 5.0;
  localparam int REQ_LAT = 4;
  localparam int RSP_LAT = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, dir_write = 1;
  logic [15:0] req_addr = 0;
  logic [7:0] req_size = 0;
  logic [3:0] req_id = 0;
  logic [1:0] req_prio = 0;
  logic req_ready, iss_valid, iss_write, rsp_valid, rsp_write, retry, draining;
  logic [15:0] iss_addr, rsp_addr, rd_rejects, wr_rejects;
  logic [7:0] iss_size;
  logic [3:0] iss_id, rsp_id;

  qos_req_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_id(req_id), .req_prio(req_prio), .dir_write(dir_write),
    .iss_valid(iss_valid), .iss_write(iss_write), .iss_addr(iss_addr),
    .iss_size(iss_size), .iss_id(iss_id), .rsp_valid(rsp_valid),
    .rsp_write(rsp_write), .rsp_addr(rsp_addr), .rsp_id(rsp_id),
    .retry(retry), .draining(draining), .rd_rejects(rd_rejects),
    .wr_rejects(wr_rejects));

  always #(CLK/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int n_iss = 0, n_rsp = 0;
  int iss_cyc [16], iss_idv [16], iss_wv [16], iss_rt [16];
  int rsp_cyc [16], rsp_idv [16];

  always @(posedge clk) cyc++;
  always @(negedge clk) begin
    if (iss_valid && n_iss < 16) begin
      iss_cyc[n_iss] = cyc; iss_idv[n_iss] = iss_id;
      iss_wv[n_iss] = iss_write; iss_rt[n_iss] = retry; n_iss++;
    end
    if (rsp_valid && n_rsp < 16) begin
      rsp_cyc[n_rsp] = cyc; rsp_idv[n_rsp] = rsp_id; n_rsp++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic dir, input logic w, input logic [7:0] sz,
                      input logic [1:0] pr, input logic [3:0] id, output logic rdy);
    @(negedge clk);
    dir_write = dir; req_write = w; req_size = sz; req_prio = pr; req_id = id;
    req_addr = {8'h00, id, 4'h0}; req_valid = 1;
    #1 rdy = req_ready;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  // {expected ready, priority, id, size}
  localparam logic [19:0] VEC [6] = '{
    20'h1_0_1_10, 20'h1_2_2_11, 20'h1_1_3_00,
    20'h0_3_4_30, 20'h1_2_5_20, 20'h0_0_6_01 };

  localparam int EXP_ID [7] = '{2, 5, 3, 1, 9, 10, 11};
  localparam int EXP_W  [7] = '{0, 0, 0, 0, 1, 0, 0};
  localparam int EXP_RT [7] = '{1, 0, 0, 0, 1, 0, 0};

  initial begin
    #(CLK * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk("R10 draining", draining, 0);
    chk("R10 iss_valid", iss_valid, 0);
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 retry", retry, 0);
    chk("R10 counters", rd_rejects + wr_rejects, 0);
    chk("R10 ready", req_ready, 1);

    // R1 R2 R4: fill reads while writes are selected
    for (int i = 0; i < 6; i++) begin
      send(1'b1, 1'b0, VEC[i][7:0], VEC[i][13:12], VEC[i][11:8], r);
      chk($sformatf("R2 R1 vec%0d ready", i), r, VEC[i][16]);
    end
    @(negedge clk);
    chk("R2 rd_rejects", rd_rejects, 2);
    chk("R8 draining", draining, 1);
    chk("R4 no issue on other direction", n_iss, 0);

    // R3 R7: switch to reads, fill write budget and reject one write
    send(1'b0, 1'b1, 8'd64, 2'd3, 4'd9, r);
    chk("R3 write accept", r, 1);
    send(1'b0, 1'b1, 8'd1, 2'd0, 4'd7, r);
    chk("R3 write reject", r, 0);
    repeat (25) @(negedge clk);
    chk("R3 wr_rejects", wr_rejects, 1);
    chk("R3 rd_rejects unchanged", rd_rejects, 2);
    chk("R4 read issues", n_iss, 4);
    for (int i = 1; i < 4; i++)
      chk($sformatf("R5 spacing %0d", i), iss_cyc[i] - iss_cyc[i-1], REQ_LAT);

    // R7: write issue carries the pending write retry
    dir_write = 1;
    repeat (10) @(negedge clk);
    chk("R8 drained", draining, 0);

    // R9: accept and free in the same edge
    send(1'b1, 1'b0, 8'd16, 2'd1, 4'd10, r);
    send(1'b0, 1'b0, 8'd32, 2'd0, 4'd11, r);
    dir_write = 1;
    chk("R9 accept during issue", r, 1);
    req_write = 0; req_size = 8'd64;
    #1 chk("R9 four more fit", req_ready, 1);
    req_size = 8'd80;
    #1 chk("R9 five more refused", req_ready, 0);
    @(negedge clk);
    dir_write = 0;
    repeat (15) @(negedge clk);
    chk("R8 final drained", draining, 0);

    chk("R4 issue count", n_iss, 7);
    for (int i = 0; i < 7; i++) begin
      chk($sformatf("R4 issue %0d id", i), iss_idv[i], EXP_ID[i]);
      chk($sformatf("R4 issue %0d dir", i), iss_wv[i], EXP_W[i]);
      chk($sformatf("R7 issue %0d retry", i), iss_rt[i], EXP_RT[i]);
    end
    chk("R6 response count", n_rsp, n_iss);
    for (int i = 0; i < n_rsp && i < 16; i++) begin
      chk($sformatf("R6 rsp %0d delay", i), rsp_cyc[i] - iss_cyc[i], RSP_LAT);
      chk($sformatf("R6 rsp %0d id", i), rsp_idv[i], iss_idv[i]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule